// File: doc/BRIEF.md
# Size-Selectable Unsigned Multiply Unit

This execution unit multiplies an implied accumulator operand by a source operand, both unsigned. The operand width is 8, 16 or 32 bits. It returns a product twice that width. The low half goes back to the accumulator. The high half goes to a paired extension register, except in byte mode, where the whole 16-bit product lands in the accumulator alone. Alongside the product, the unit reports a carry flag and an overflow flag. Both are set when the upper half of the product is non-zero.

The surrounding pipeline hands over the operand values, the opcode form and the operand-size attribute together with a one-cycle `start` pulse. This is a single-beat transfer, so plain control pins are used in place of a valid/ready stream. A request seen while the unit is `busy` is dropped, not queued. The result cannot be stalled. Write-back data, byte-lane write enables and flag write enables are valid only during the single cycle in which `done` is high, and the register file must take them then. The datapath is radix-2 shift-and-add and consumes one source bit per clock.

Top module: `umul_exec`

## Requirements
- R1: In byte mode, the product of `acc_in[7:0]` and `src_in[7:0]` appears on `acc_out[15:0]`. `acc_be` is 4'b0011 and `ext_be` is 4'b0000 during `done`.
- R2: Mode selection works as follows. `wide_op`=0 selects byte mode whatever the value of `osz32`. `wide_op`=1 with `osz32`=0 selects word mode. `wide_op`=1 with `osz32`=1 selects doubleword mode.
- R3: In word mode, `acc_out[15:0]` carries bits 15:0 of `acc_in[15:0]`×`src_in[15:0]` and `ext_out[15:0]` carries bits 31:16. Both `acc_be` and `ext_be` are 4'b0011, so bits 31:16 of either register keep their old value.
- R4: In doubleword mode, `acc_out` carries bits 31:0 and `ext_out` carries bits 63:32 of the 64-bit product. Both `acc_be` and `ext_be` are 4'b1111.
- R5: The multiplication is unsigned in every mode. All-ones operands give the largest product, for example 0xFF×0xFF = 0xFE01.
- R6: During `done`, `cf_out` and `of_out` are both 1 when the upper half of the product is non-zero and both 0 otherwise, and `cfof_we` is 1.
- R7: `szap_out` (bit 3 sign, bit 2 zero, bit 1 aux-carry, bit 0 parity) is all zero and `szap_we` is all zero.
- R8: `done` rises exactly N rising edges after the edge that samples `start`, where N is 8, 16 or 32 for the mode. It stays high for exactly one cycle.
- R9: A `start` seen while `busy` is ignored. Operands, opcode form and size are captured at the accepted `start` edge, so later input changes do not alter the result or its timing.
- R10: Synchronous reset `rst` returns the unit to idle, with `busy` and `done` low. Outside the `done` cycle, every write enable (`acc_be`, `ext_be`, `cfof_we`) is low.
- R11: Operand bits above the selected width (`acc_in`/`src_in` bits 31:8 in byte mode, bits 31:16 in word mode) have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request pulse, accepted when not busy |
| wide_op | input | 1 | Opcode form: 0 byte form, 1 word/doubleword form |
| osz32 | input | 1 | Operand-size attribute: 1 selects 32 bits in the wide form |
| acc_in | input | 32 | Implied accumulator operand |
| src_in | input | 32 | Source operand |
| busy | output | 1 | Multiply in progress |
| done | output | 1 | One-cycle result-valid pulse |
| acc_out | output | 32 | Accumulator write-back data |
| acc_be | output | 4 | Accumulator byte-lane write enables |
| ext_out | output | 32 | Extension register write-back data |
| ext_be | output | 4 | Extension register byte-lane write enables |
| cf_out | output | 1 | Carry flag value |
| of_out | output | 1 | Overflow flag value |
| cfof_we | output | 1 | Carry/overflow write enable |
| szap_out | output | 4 | Undefined flags, driven zero |
| szap_we | output | 4 | Undefined flag write enables, held low |

## Verification
The embedded assertions check, on every cycle, the following: write enables stay quiet outside `done`, `done` lasts a single cycle, the multiplier is fully consumed when `done` fires, and a `start` during `busy` does not disturb the iteration count. They also check that the flags agree with the upper half actually written back. Only the bench scenarios can show that the product values are correct, how the opcode form and size attribute map to each mode, and the exact N-cycle latency. The same holds for the stability of results when inputs are scrambled after capture and for recovery from a reset in mid-operation.

// File: rtl/umul_pkg.sv
package umul_pkg;
  typedef enum logic [1:0] {
    MSZ_BYTE  = 2'd0,
    MSZ_WORD  = 2'd1,
    MSZ_DWORD = 2'd2
  } msize_e;
endpackage

// File: rtl/umul_size_dec.sv
module umul_size_dec
  import umul_pkg::*;
(
  input  logic   wide_op,
  input  logic   osz32,
  output msize_e size
);
  always_comb begin
    if (!wide_op)   size = MSZ_BYTE;
    else if (osz32) size = MSZ_DWORD;
    else            size = MSZ_WORD;
  end
endmodule

// File: rtl/umul_shift_add.sv
module umul_shift_add
  import umul_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  msize_e        size,
  input  logic [DW-1:0] a_in,
  input  logic [DW-1:0] b_in,
  output logic          busy,
  output logic          done,
  output msize_e        size_q,
  output logic [2*DW-1:0] prod
);
  localparam int PW = 2 * DW;
  localparam int HW = DW / 2;
  localparam int QW = DW / 4;
  localparam int CW = $clog2(DW + 1);

  logic [PW-1:0] acc_q, mcand_q;
  logic [DW-1:0] mplr_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q, done_q;
  logic [DW-1:0] a_m, b_m;
  logic [CW-1:0] nbits;

  // Operand masking and iteration count by size
  always_comb begin
    case (size)
      MSZ_BYTE: begin
        a_m   = {{(DW-QW){1'b0}}, a_in[QW-1:0]};
        b_m   = {{(DW-QW){1'b0}}, b_in[QW-1:0]};
        nbits = CW'(QW);
      end
      MSZ_WORD: begin
        a_m   = {{(DW-HW){1'b0}}, a_in[HW-1:0]};
        b_m   = {{(DW-HW){1'b0}}, b_in[HW-1:0]};
        nbits = CW'(HW);
      end
      default: begin
        a_m   = a_in;
        b_m   = b_in;
        nbits = CW'(DW);
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      mcand_q <= '0;
      mplr_q  <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      size_q  <= MSZ_BYTE;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          acc_q   <= '0;
          mcand_q <= {{DW{1'b0}}, a_m};
          mplr_q  <= b_m;
          cnt_q   <= nbits;
          size_q  <= size;
          busy_q  <= 1'b1;
        end
      end else begin
        if (mplr_q[0]) acc_q <= acc_q + mcand_q;
        mcand_q <= mcand_q << 1;
        mplr_q  <= mplr_q >> 1;
        cnt_q   <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign prod = acc_q;

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  // R8
  mplr_spent_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (mplr_q == '0));

  // R8
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (cnt_q != '0 && cnt_q <= CW'(DW)));

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && start && cnt_q > CW'(1)) |=> (busy_q && cnt_q == $past(cnt_q) - CW'(1)));
endmodule

// File: rtl/umul_wb.sv
module umul_wb
  import umul_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            done,
  input  msize_e          size,
  input  logic [2*DW-1:0] prod,
  output logic [DW-1:0]   acc_out,
  output logic [DW/8-1:0] acc_be,
  output logic [DW-1:0]   ext_out,
  output logic [DW/8-1:0] ext_be,
  output logic            hi_nz,
  output logic            cfof_we
);
  localparam int PW = 2 * DW;
  localparam int HW = DW / 2;
  localparam int QW = DW / 4;
  localparam int NL = DW / 8;
  localparam int LW = $clog2(NL + 1);

  logic [LW-1:0] acc_lanes, ext_lanes;

  always_comb begin
    case (size)
      MSZ_BYTE: begin
        acc_out   = {{(DW-HW){1'b0}}, prod[HW-1:0]};
        ext_out   = '0;
        hi_nz     = (prod[2*QW-1:QW] != '0);
        acc_lanes = LW'(HW / 8);
        ext_lanes = '0;
      end
      MSZ_WORD: begin
        acc_out   = {{(DW-HW){1'b0}}, prod[HW-1:0]};
        ext_out   = {{(DW-HW){1'b0}}, prod[DW-1:HW]};
        hi_nz     = (prod[DW-1:HW] != '0);
        acc_lanes = LW'(HW / 8);
        ext_lanes = LW'(HW / 8);
      end
      default: begin
        acc_out   = prod[DW-1:0];
        ext_out   = prod[PW-1:DW];
        hi_nz     = (prod[PW-1:DW] != '0);
        acc_lanes = LW'(NL);
        ext_lanes = LW'(NL);
      end
    endcase
  end

  genvar i;
  generate
    for (i = 0; i < NL; i++) begin : g_lane
      assign acc_be[i] = done && (LW'(i) < acc_lanes);
      assign ext_be[i] = done && (LW'(i) < ext_lanes);
    end
  endgenerate

  assign cfof_we = done;

  // R10
  idle_we_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> (acc_be == '0 && ext_be == '0 && !cfof_we));

  // R1
  byte_ext_chk: assert property (@(posedge clk) disable iff (rst)
    (done && size == MSZ_BYTE) |-> (ext_be == '0 && acc_out[DW-1:HW] == '0));
endmodule

// File: rtl/umul_exec.sv
module umul_exec
  import umul_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            wide_op,
  input  logic            osz32,
  input  logic [DW-1:0]   acc_in,
  input  logic [DW-1:0]   src_in,
  output logic            busy,
  output logic            done,
  output logic [DW-1:0]   acc_out,
  output logic [DW/8-1:0] acc_be,
  output logic [DW-1:0]   ext_out,
  output logic [DW/8-1:0] ext_be,
  output logic            cf_out,
  output logic            of_out,
  output logic            cfof_we,
  output logic [3:0]      szap_out,
  output logic [3:0]      szap_we
);
  localparam int QW = DW / 4;
  localparam int PW = 2 * DW;

  msize_e        size_req, size_q;
  logic [PW-1:0] prod;
  logic          hi_nz;

  umul_size_dec u_dec (
    .wide_op (wide_op),
    .osz32   (osz32),
    .size    (size_req)
  );

  umul_shift_add #(.DW(DW)) u_core (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .size   (size_req),
    .a_in   (acc_in),
    .b_in   (src_in),
    .busy   (busy),
    .done   (done),
    .size_q (size_q),
    .prod   (prod)
  );

  umul_wb #(.DW(DW)) u_wb (
    .clk     (clk),
    .rst     (rst),
    .done    (done),
    .size    (size_q),
    .prod    (prod),
    .acc_out (acc_out),
    .acc_be  (acc_be),
    .ext_out (ext_out),
    .ext_be  (ext_be),
    .hi_nz   (hi_nz),
    .cfof_we (cfof_we)
  );

  assign cf_out   = hi_nz;
  assign of_out   = hi_nz;
  assign szap_out = 4'b0000;
  assign szap_we  = 4'b0000;

  // R6
  flag_upper_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (cf_out == ((size_q == MSZ_BYTE) ? (acc_out[2*QW-1:QW] != '0) : (ext_out != '0))));

  // R6
  flag_pair_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (cf_out == of_out && cfof_we));
endmodule

// File: tb/sim_umul_exec.sv
module sim_umul_exec;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0, wide_op = 1'b0, osz32 = 1'b0;
  logic [31:0] acc_in = '0, src_in = '0;
  logic        busy, done, cf_out, of_out, cfof_we;
  logic [31:0] acc_out, ext_out;
  logic [3:0]  acc_be, ext_be, szap_out, szap_we;

  int nchk = 0;
  int nerr = 0;
  int cycles = 0;

  umul_exec #(.DW(32)) u0 (
    .clk(clk), .rst(rst), .start(start), .wide_op(wide_op), .osz32(osz32),
    .acc_in(acc_in), .src_in(src_in), .busy(busy), .done(done),
    .acc_out(acc_out), .acc_be(acc_be), .ext_out(ext_out), .ext_be(ext_be),
    .cf_out(cf_out), .of_out(of_out), .cfof_we(cfof_we),
    .szap_out(szap_out), .szap_we(szap_we)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nerr++;
      $display("FAIL R8 watchdog actual=%0d expected<150000", cycles);
      $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int width_of(input bit w, input bit o);
    if (!w) return 8;
    return o ? 32 : 16;
  endfunction

  function automatic logic [63:0] model(input int n, input logic [31:0] a, input logic [31:0] b);
    logic [63:0] am, bm;
    logic [31:0] msk;
    msk = (n == 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
    am = {32'h0, a & msk};
    bm = {32'h0, b & msk};
    return am * bm;
  endfunction

  task automatic run_op(input bit w, input bit o, input logic [31:0] a, input logic [31:0] b, input bit poke);
    int n, cyc;
    logic [63:0] p;
    logic hi;
    n = width_of(w, o);
    p = model(n, a, b);
    @(negedge clk);
    wide_op = w; osz32 = o; acc_in = a; src_in = b; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    acc_in = $urandom; src_in = $urandom; wide_op = ~w; osz32 = ~o;
    cyc = 0;
    while (!done && cyc < 40) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      start = (poke && cyc == 2);
    end
    start = 1'b0;
    chk(cyc == n, "R8 latency", 64'(cyc), 64'(n));
    if (n == 8) begin
      hi = (p[15:8] != 0);
      chk(acc_out[15:0] == p[15:0], "R1/R11 byte product", 64'(acc_out[15:0]), p[15:0]);
      chk(acc_be == 4'b0011 && ext_be == 4'b0000, "R1 byte enables", {acc_be, ext_be}, 8'h30);
    end else if (n == 16) begin
      hi = (p[31:16] != 0);
      chk({ext_out[15:0], acc_out[15:0]} == p[31:0], "R3/R11 word product", {ext_out[15:0], acc_out[15:0]}, p[31:0]);
      chk(acc_be == 4'b0011 && ext_be == 4'b0011, "R3 word enables", {acc_be, ext_be}, 8'h33);
    end else begin
      hi = (p[63:32] != 0);
      chk({ext_out, acc_out} == p, "R4 dword product", {ext_out, acc_out}, p);
      chk(acc_be == 4'b1111 && ext_be == 4'b1111, "R4 dword enables", {acc_be, ext_be}, 8'hFF);
    end
    chk(cf_out == hi && of_out == hi && cfof_we, "R6 flags", {cf_out, of_out, cfof_we}, {hi, hi, 1'b1});
    chk(szap_out == 0 && szap_we == 0, "R7 undefined flags", {szap_out, szap_we}, 0);
    @(posedge clk);
    @(negedge clk);
    chk(!done, "R8 done pulse width", 64'(done), 0);
    chk(acc_be == 0 && ext_be == 0 && !cfof_we, "R10 enables idle", {acc_be, ext_be, cfof_we}, 0);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!busy && !done, "R10 reset idle", {busy, done}, 0);
    chk(acc_be == 0 && ext_be == 0 && !cfof_we, "R10 reset enables", {acc_be, ext_be, cfof_we}, 0);
    rst = 1'b0;

    // R1 R5 R11: all-ones byte with junk upper bits
    run_op(1'b0, 1'b0, 32'hDEAD_BEFF, 32'hA5A5_A5FF, 1'b0);
    // R6 small byte product, upper half zero
    run_op(1'b0, 1'b0, 32'h0000_0003, 32'h0000_0004, 1'b0);
    // R2: osz32 ignored in byte form
    run_op(1'b0, 1'b1, 32'hFFFF_FF10, 32'h1234_5620, 1'b0);
    // R3 R5 word all ones with junk upper
    run_op(1'b1, 1'b0, 32'h7777_FFFF, 32'h8888_FFFF, 1'b0);
    run_op(1'b1, 1'b0, 32'h0000_00FF, 32'h0000_0100, 1'b0);
    // R4 R5 dword
    run_op(1'b1, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
    run_op(1'b1, 1'b1, 32'h0000_0000, 32'h8765_4321, 1'b0);
    run_op(1'b1, 1'b1, 32'h0001_0000, 32'h0000_FFFF, 1'b0);
    // R9: start while busy ignored, inputs scrambled after capture
    run_op(1'b1, 1'b1, 32'h1357_9BDF, 32'h2468_ACE0, 1'b1);
    run_op(1'b0, 1'b0, 32'h0000_0081, 32'h0000_0002, 1'b1);

    // R10: reset in mid-operation
    @(negedge clk);
    wide_op = 1'b1; osz32 = 1'b1; acc_in = 32'hFFFF_FFFF; src_in = 32'h3; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(!busy && !done, "R10 mid-op reset idle", {busy, done}, 0);
    chk(acc_be == 0 && ext_be == 0 && !cfof_we, "R10 mid-op reset enables", {acc_be, ext_be, cfof_we}, 0);
    repeat (40) @(posedge clk);
    @(negedge clk);
    chk(!done, "R10 no done after reset", 64'(done), 0);

    for (int k = 0; k < 60; k++) begin
      logic [31:0] a, b;
      bit w, o;
      a = $urandom; b = $urandom;
      w = $urandom_range(1, 0); o = $urandom_range(1, 0);
      if ($urandom_range(3, 0) == 0) b = b & 32'h0000_0003;
      run_op(w, o, a, b, (k % 7) == 3);
    end

    $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule